// File: doc/BRIEF.md
# Serial Flash Erase Command Front-End

This block sits on the slave side of a serial NOR flash bus. It samples the data-in line on each rising serial clock while chip select is low and counts the bits. It decodes an 8-bit opcode at the start of each frame. Five commands are recognised: write enable, 64 KB block erase with a 24-bit address, chip erase, deep power-down and wake-up. The wake-up command also returns a one-byte device identifier. The block owns the write-enable latch, the busy flag and the power-down state.

All serial inputs are sampled in the system clock domain, and edges are found by comparison with the previous sample. A command takes effect only when chip select rises, and only at the exact bit count that the command defines. A committed command is then gated by the busy flag, the power-down state, the write-enable latch and the block-protect field. An accepted erase leaves the block as a one-cycle start pulse with the inclusive byte range to erase. A parameterised down-counter then stands in for the self-timed erase cycle, and busy stays high until the counter ends.

Top module: `flash_erase_cmd`

## Requirements
- R1: Opcode D8h followed by a 24-bit address (MSB first, 32 bits in all) starts a block erase. The range is `erase_lo` = block base and `erase_hi` = block base + FFFFh. The block index is taken from address bits 19:16, and bits 23:20 are ignored.
- R2: Opcode 60h or C7h, 8 bits in all, starts a chip erase over 000000h to 0FFFFFh.
- R3: Opcode 06h sets `wel`. An erase is accepted only while `wel` is 1. Without it, no start pulse is issued.
- R4: A frame is committed only when `cs_n` rises after exactly 8 bits (single-byte commands) or exactly 32 bits (block erase). A rise at any other count has no effect, and `wel` and `pwr_down` keep their values.
- R5: An accepted erase gives a `erase_start` pulse exactly one clock long, in the cycle after the commit. `wip` rises in the same cycle and stays high for exactly BLK_ERASE_CYC clocks (block) or CHIP_ERASE_CYC clocks (chip).
- R6: `wel` returns to 0 in the same cycle that `wip` falls at the end of an erase.
- R7: The block-protect field `bp` locks the top 2^(bp-1) blocks for bp = 1 to 5, all 16 blocks for bp = 6 or 7, and nothing for bp = 0. A block erase aimed at a locked block is refused, and a chip erase is refused whenever bp is not 0. A refused erase leaves `wel` at 1.
- R8: Opcode B9h sets `pwr_down`. While it is set, every command other than ABh is ignored: write enable, both erases and B9h.
- R9: Opcode ABh with 8 or more bits clears `pwr_down`. If the frame goes on past 32 bits, `so` shifts out DEVICE_ID MSB first, one bit per falling `sclk`, starting at the falling edge after the 32nd rising edge. At all other times `so` is 0.
- R10: While `wip` is 1, every commit is ignored. This includes a chip select rise that lands in the last busy cycle. A rise one cycle later is accepted.
- R11: After reset, `wip`, `wel`, `pwr_down`, `erase_start` and `so` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, sampled on clk |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| bp | input | 3 | Block-protect field |
| so | output | 1 | Serial data out (device identifier) |
| wip | output | 1 | Erase cycle in progress |
| wel | output | 1 | Write-enable latch |
| pwr_down | output | 1 | Deep power-down state |
| erase_start | output | 1 | One-cycle erase start pulse |
| erase_lo | output | 24 | First byte address of the erase |
| erase_hi | output | 24 | Last byte address of the erase |

## Verification
Two events can fall in the same clock: the end of an erase cycle, which clears `wel`, and the commit of a write-enable frame, which would set it. The bench shifts a write-enable opcode while the erase is still running. It then raises chip select either in the very last busy cycle or in the cycle after, counting clocks from the observed start pulse. In the first case `wel` must end at 0 and the erase length must be unchanged. In the second case `wel` must end at 1.

// File: rtl/fec_pkg.sv
package fec_pkg;

  localparam int unsigned BITCNT_W = 6;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_BLK_ER  = 8'hD8;
  localparam logic [7:0] OP_CHIP_A  = 8'h60;
  localparam logic [7:0] OP_CHIP_B  = 8'hC7;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;
  localparam logic [7:0] OP_WAKE    = 8'hAB;

  localparam logic [BITCNT_W-1:0] LEN_OPCODE = 6'd8;
  localparam logic [BITCNT_W-1:0] LEN_ADDR   = 6'd32;
  localparam logic [BITCNT_W-1:0] ID_FIRST   = 6'd32;
  localparam logic [BITCNT_W-1:0] ID_END     = 6'd40;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WREN,
    CMD_BLK,
    CMD_CHIP,
    CMD_SLEEP,
    CMD_WAKE
  } cmd_e;

  // Number of top blocks locked by a protect code, clipped to the array size.
  function automatic int unsigned locked_span(input logic [2:0] bp,
                                              input int unsigned nblk);
    int unsigned span;
    if (bp == 3'd0) return 0;
    span = 32'd1 << (32'(bp) - 32'd1);
    if (span > nblk) span = nblk;
    return span;
  endfunction

  function automatic logic blk_locked(input int unsigned blk,
                                      input logic [2:0] bp,
                                      input int unsigned nblk);
    return blk >= (nblk - locked_span(bp, nblk));
  endfunction

endpackage

// File: rtl/fec_serial_in.sv
module fec_serial_in
  import fec_pkg::*;
#(
  parameter int SHIFT_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                si,
  output logic                sclk_fall,
  output logic                cs_rise,
  output logic [BITCNT_W-1:0] bit_cnt,
  output logic [SHIFT_W-1:0]  shift_q,
  output logic [7:0]          opcode_q
);
  logic sclk_d, cs_d;
  logic sclk_rise, cs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
    end
  end

  assign sclk_rise = sclk & ~sclk_d & ~cs_n;
  assign sclk_fall = ~sclk & sclk_d & ~cs_n;
  assign cs_rise   = cs_n & ~cs_d;
  assign cs_fall   = ~cs_n & cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shift_q  <= '0;
      opcode_q <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shift_q <= {shift_q[SHIFT_W-2:0], si};
      if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == LEN_OPCODE - 1'b1) opcode_q <= {shift_q[6:0], si};
    end
  end
endmodule

// File: rtl/fec_erase_timer.sv
module fec_erase_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1)) && !load;
endmodule

// File: rtl/fec_id_out.sv
module fec_id_out
  import fec_pkg::*;
#(
  parameter logic [7:0] ID = 8'h13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk_fall,
  input  logic                enable,
  input  logic [BITCNT_W-1:0] bit_cnt,
  output logic                so
);
  logic       in_window;
  logic [2:0] idx;

  assign in_window = enable && (bit_cnt >= ID_FIRST) && (bit_cnt < ID_END);
  assign idx       = 3'(ID_END - 1'b1 - bit_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          so <= 1'b0;
    else if (cs_n)       so <= 1'b0;
    else if (sclk_fall)  so <= in_window ? ID[idx] : 1'b0;
  end
endmodule

// File: rtl/flash_erase_cmd.sv
module flash_erase_cmd
  import fec_pkg::*;
#(
  parameter int         NUM_BLOCKS     = 16,
  parameter int         BLOCK_LOG2     = 16,
  parameter int         ADDR_W         = 24,
  parameter int         BLK_ERASE_CYC  = 200,
  parameter int         CHIP_ERASE_CYC = 600,
  parameter logic [7:0] DEVICE_ID      = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              si,
  input  logic [2:0]        bp,
  output logic              so,
  output logic              wip,
  output logic              wel,
  output logic              pwr_down,
  output logic              erase_start,
  output logic [ADDR_W-1:0] erase_lo,
  output logic [ADDR_W-1:0] erase_hi
);
  localparam int BLK_IDX_W = $clog2(NUM_BLOCKS);
  localparam int TMR_MAX   = (CHIP_ERASE_CYC > BLK_ERASE_CYC) ? CHIP_ERASE_CYC : BLK_ERASE_CYC;
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam logic [ADDR_W-1:0] BLOCK_MASK = ADDR_W'((64'd1 << BLOCK_LOG2) - 64'd1);
  localparam logic [ADDR_W-1:0] ARRAY_TOP  = ADDR_W'((64'(NUM_BLOCKS) << BLOCK_LOG2) - 64'd1);

  function automatic logic [BLK_IDX_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return BLK_IDX_W'(a >> BLOCK_LOG2);
  endfunction

  function automatic logic [ADDR_W-1:0] block_base(input logic [BLK_IDX_W-1:0] b);
    return ADDR_W'(b) << BLOCK_LOG2;
  endfunction

  // Named internal events, visible to the bound checker
  logic                sclk_fall, cs_rise;
  logic [BITCNT_W-1:0] bit_cnt;
  logic [ADDR_W-1:0]   shift_q;
  logic [7:0]          opcode_q;
  cmd_e                cmd;
  logic [BLK_IDX_W-1:0] tgt_blk;
  logic                ev_wren, ev_sleep, ev_wake, ev_blk_go, ev_chip_go, ev_erase_done;
  logic                tmr_busy;
  logic                wel_q, dpd_q, start_q;
  logic [ADDR_W-1:0]   lo_q, hi_q;

  fec_serial_in #(.SHIFT_W(ADDR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .si        (si),
    .sclk_fall (sclk_fall),
    .cs_rise   (cs_rise),
    .bit_cnt   (bit_cnt),
    .shift_q   (shift_q),
    .opcode_q  (opcode_q)
  );

  // Commit decode: only at a chip select rise, never while busy
  always_comb begin
    cmd = CMD_NONE;
    if (cs_rise && !tmr_busy) begin
      if (opcode_q == OP_WAKE && bit_cnt >= LEN_OPCODE) begin
        cmd = CMD_WAKE;
      end else if (!dpd_q) begin
        if (bit_cnt == LEN_OPCODE) begin
          case (opcode_q)
            OP_WREN:              cmd = CMD_WREN;
            OP_CHIP_A, OP_CHIP_B: cmd = CMD_CHIP;
            OP_SLEEP:             cmd = CMD_SLEEP;
            default:              cmd = CMD_NONE;
          endcase
        end else if (bit_cnt == LEN_ADDR && opcode_q == OP_BLK_ER) begin
          cmd = CMD_BLK;
        end
      end
    end
  end

  assign tgt_blk    = block_of(shift_q);
  assign ev_wren    = (cmd == CMD_WREN);
  assign ev_sleep   = (cmd == CMD_SLEEP);
  assign ev_wake    = (cmd == CMD_WAKE);
  assign ev_blk_go  = (cmd == CMD_BLK) && wel_q &&
                      !blk_locked(32'(tgt_blk), bp, NUM_BLOCKS);
  assign ev_chip_go = (cmd == CMD_CHIP) && wel_q && (bp == 3'd0);

  fec_erase_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_blk_go | ev_chip_go),
    .load_val (ev_chip_go ? TMR_W'(CHIP_ERASE_CYC) : TMR_W'(BLK_ERASE_CYC)),
    .busy     (tmr_busy),
    .done     (ev_erase_done)
  );

  fec_id_out #(.ID(DEVICE_ID)) u_id (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk_fall (sclk_fall),
    .enable    ((opcode_q == OP_WAKE) && !tmr_busy),
    .bit_cnt   (bit_cnt),
    .so        (so)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      dpd_q   <= 1'b0;
      start_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      start_q <= ev_blk_go | ev_chip_go;
      if (ev_blk_go) begin
        lo_q <= block_base(tgt_blk);
        hi_q <= block_base(tgt_blk) | BLOCK_MASK;
      end else if (ev_chip_go) begin
        lo_q <= '0;
        hi_q <= ARRAY_TOP;
      end
      if (ev_erase_done)  wel_q <= 1'b0;
      else if (ev_wren)   wel_q <= 1'b1;
      if (ev_sleep)       dpd_q <= 1'b1;
      else if (ev_wake)   dpd_q <= 1'b0;
    end
  end

  assign wip         = tmr_busy;
  assign wel         = wel_q;
  assign pwr_down    = dpd_q;
  assign erase_start = start_q;
  assign erase_lo    = lo_q;
  assign erase_hi    = hi_q;
endmodule

// File: rtl/fec_checker.sv
module fec_checker
  import fec_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wip,
  input logic                wel,
  input logic                pwr_down,
  input logic                erase_start,
  input logic [ADDR_W-1:0]   erase_lo,
  input logic [ADDR_W-1:0]   erase_hi,
  input logic                cs_rise,
  input logic [BITCNT_W-1:0] bit_cnt
);
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(wel)); // R3

  AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($past(cs_rise) && ($past(bit_cnt) == LEN_OPCODE || $past(bit_cnt) == LEN_ADDR))); // R4

  AST_START_RAISES_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> wip); // R5

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R5

  AST_RANGE_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_lo <= erase_hi)); // R1

  AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel); // R6

  AST_NO_SLEEP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_down && wip)); // R8

  AST_NO_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !$past(pwr_down)); // R8

  AST_BUSY_FREEZES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> ($stable(wel) && $stable(pwr_down))); // R10
endmodule

bind flash_erase_cmd fec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wip         (wip),
  .wel         (wel),
  .pwr_down    (pwr_down),
  .erase_start (erase_start),
  .erase_lo    (erase_lo),
  .erase_hi    (erase_hi),
  .cs_rise     (cs_rise),
  .bit_cnt     (bit_cnt)
);

// File: tb/sim_flash_erase_cmd.sv
`timescale 1ns/1ps
module sim_flash_erase_cmd;
  localparam int BLK_CYC  = 200;
  localparam int CHIP_CYC = 600;
  localparam logic [7:0] DEV_ID = 8'h13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic [2:0] bp = 3'd0;
  logic so, wip, wel, pwr_down, erase_start;
  logic [23:0] erase_lo, erase_hi;

  int nchk = 0;
  int nerr = 0;
  int starts = 0;
  int run_len = 0;
  int last_len = 0;
  logic [23:0] cap_lo = '0;
  logic [23:0] cap_hi = '0;

  always #4 clk = ~clk;

  flash_erase_cmd #(
    .NUM_BLOCKS(16), .BLOCK_LOG2(16), .ADDR_W(24),
    .BLK_ERASE_CYC(BLK_CYC), .CHIP_ERASE_CYC(CHIP_CYC), .DEVICE_ID(DEV_ID)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si), .bp(bp),
    .so(so), .wip(wip), .wel(wel), .pwr_down(pwr_down),
    .erase_start(erase_start), .erase_lo(erase_lo), .erase_hi(erase_hi)
  );

  // Observers: start pulses, captured range, length of each busy run
  always @(negedge clk) begin
    if (erase_start) begin
      starts++;
      cap_lo = erase_lo;
      cap_hi = erase_hi;
    end
    if (wip) run_len++;
    else if (run_len != 0) begin
      last_len = run_len;
      run_len = 0;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b);
    si = b;
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_cmd(input logic [31:0] data, input int n);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) spi_bit(data[i]);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (wip) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_erase(input string req, input int n0,
                              input logic [23:0] lo, input logic [23:0] hi, input int cyc);
    check(req, "start pulse count", starts, n0 + 1);
    check(req, "wip after start", wip, 1);
    check(req, "erase_lo", cap_lo, lo);
    check(req, "erase_hi", cap_hi, hi);
    wait_idle();
    check(req, "busy length", last_len, cyc);
    check("R6", "wel after erase", wel, 0);
  endtask

  task automatic expect_no_erase(input string req, input int n0);
    check(req, "no start pulse", starts, n0);
    check(req, "wip stays low", wip, 0);
  endtask

  task automatic t_reset();
    check("R11", "wip", wip, 0);
    check("R11", "wel", wel, 0);
    check("R11", "pwr_down", pwr_down, 0);
    check("R11", "erase_start", erase_start, 0);
    check("R11", "so", so, 0);
  endtask

  task automatic t_chip_basic();
    int n0;
    n0 = starts;
    spi_cmd(32'h60, 8);
    expect_no_erase("R3", n0);
    spi_cmd(32'h06, 8);
    check("R3", "wel set by 06h", wel, 1);
    n0 = starts;
    spi_cmd(32'h60, 8);
    expect_erase("R2", n0, 24'h000000, 24'h0FFFFF, CHIP_CYC);
    spi_cmd(32'h06, 8);
    n0 = starts;
    spi_cmd(32'hC7, 8);
    expect_erase("R2", n0, 24'h000000, 24'h0FFFFF, CHIP_CYC);
  endtask

  task automatic t_block_basic();
    int n0;
    spi_cmd(32'h06, 8);
    n0 = starts;
    spi_cmd({8'hD8, 24'h051234}, 32);
    expect_erase("R1", n0, 24'h050000, 24'h05FFFF, BLK_CYC);
    spi_cmd(32'h06, 8);
    n0 = starts;
    spi_cmd({8'hD8, 24'hF3ABCD}, 32);
    expect_erase("R1", n0, 24'h030000, 24'h03FFFF, BLK_CYC);
  endtask

  task automatic t_bad_count();
    int n0;
    spi_cmd(32'h06, 8);
    n0 = starts;
    spi_cmd({23'd0, 8'h60, 1'b0}, 9);
    expect_no_erase("R4", n0);
    check("R4", "wel kept after 9-bit chip erase", wel, 1);
    spi_cmd({8'hD8, 24'h0E0000} >> 1, 31);
    expect_no_erase("R4", n0);
    spi_cmd({23'd0, 8'hB9, 1'b0}, 9);
    check("R4", "pwr_down after 9-bit B9h", pwr_down, 0);
    spi_cmd({24'd0, 8'h60}, 16);
    expect_no_erase("R4", n0);
    check("R4", "wel kept after bad frames", wel, 1);
  endtask

  task automatic t_protect();
    int n0;
    bp = 3'd1;
    n0 = starts;
    spi_cmd({8'hD8, 24'h0F0000}, 32);
    expect_no_erase("R7", n0);
    check("R7", "wel kept after refused erase", wel, 1);
    spi_cmd({8'hD8, 24'h0E0000}, 32);
    expect_erase("R7", n0, 24'h0E0000, 24'h0EFFFF, BLK_CYC);
    bp = 3'd3;
    spi_cmd(32'h06, 8);
    n0 = starts;
    spi_cmd({8'hD8, 24'h0C0000}, 32);
    expect_no_erase("R7", n0);
    spi_cmd({8'hD8, 24'h0B0000}, 32);
    expect_erase("R7", n0, 24'h0B0000, 24'h0BFFFF, BLK_CYC);
    spi_cmd(32'h06, 8);
    n0 = starts;
    bp = 3'd5;
    spi_cmd({8'hD8, 24'h000000}, 32);
    expect_no_erase("R7", n0);
    bp = 3'd7;
    spi_cmd({8'hD8, 24'h000000}, 32);
    expect_no_erase("R7", n0);
    bp = 3'd2;
    spi_cmd(32'h60, 8);
    expect_no_erase("R7", n0);
    check("R7", "wel kept after refused chip erase", wel, 1);
    bp = 3'd0;
    spi_cmd(32'h60, 8);
    expect_erase("R7", n0, 24'h000000, 24'h0FFFFF, CHIP_CYC);
  endtask

  // Land the write-enable commit in the last busy cycle (late=0) or one after (late=1)
  task automatic t_busy_edge(input int late);
    spi_cmd(32'h06, 8);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 31; i >= 0; i--) spi_bit(logic'((32'hD8070000 >> i) & 32'd1));
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    do @(negedge clk); while (!erase_start);
    cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) spi_bit(logic'((8'h06 >> i) & 8'd1));
    repeat (BLK_CYC - 65 + late) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    wait_idle();
    check("R10", "busy length with overlapping frame", last_len, BLK_CYC);
    check("R10", late ? "wel after commit one cycle late" : "wel after commit in last busy cycle",
          wel, late ? 1 : 0);
  endtask

  task automatic t_busy_ignore();
    spi_cmd(32'h06, 8);
    spi_cmd({8'hD8, 24'h020000}, 32);
    check("R10", "busy during erase", wip, 1);
    spi_cmd(32'hB9, 8);
    check("R10", "B9h ignored while busy", pwr_down, 0);
    wait_idle();
  endtask

  task automatic t_sleep();
    logic [7:0] got;
    int n0;
    check("R8", "wel low before sleep", wel, 0);
    spi_cmd(32'hB9, 8);
    check("R8", "pwr_down set", pwr_down, 1);
    spi_cmd(32'h06, 8);
    check("R8", "06h ignored asleep", wel, 0);
    spi_cmd(32'hAB, 8);
    check("R9", "short ABh wakes", pwr_down, 0);
    spi_cmd(32'h06, 8);
    spi_cmd(32'hB9, 8);
    n0 = starts;
    spi_cmd(32'h60, 8);
    expect_no_erase("R8", n0);
    spi_cmd({8'hD8, 24'h010000}, 32);
    expect_no_erase("R8", n0);
    check("R8", "still asleep", pwr_down, 1);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 31; i >= 0; i--) spi_bit(logic'((32'hAB000000 >> i) & 32'd1));
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      si = 1'b0;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      got[i] = so;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", "device id on so", got, DEV_ID);
    check("R9", "so low after frame", so, 0);
    check("R9", "awake after ID read", pwr_down, 0);
    spi_cmd(32'h60, 8);
    expect_erase("R2", n0, 24'h000000, 24'h0FFFFF, CHIP_CYC);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_chip_basic();
    t_block_basic();
    t_bad_count();
    t_protect();
    t_busy_ignore();
    t_busy_edge(0);
    t_busy_edge(1);
    spi_cmd(32'h60, 8);
    wait_idle();
    t_sleep();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule